// File: doc/BRIEF.md
# Multi-Width Line Input Retimer

This block sits at the receive edge of a 155 Mb/s optical line port. The incoming line arrives in one of three shapes, chosen at run time: one bit per clock, a 4-bit nibble per clock, or a full byte per clock. Software picks the shape and the clock edge that samples the data. The block assembles whatever arrives into a byte stream with a one-cycle valid strobe, which it hands to a downstream frame aligner. The frame aligner finds byte boundaries within the frame. This block only packs the bits in arrival order.

In the two parallel shapes, each transfer carries one parity bit. The block checks that bit against a programmable sense, odd or even. A mismatch sets a sticky error flag, which software clears by writing a one. The flag drives an interrupt line, and a mask bit can block it. In the serial shape the checker is off, so the parity pin is ignored.

Top module: `line_retimer`

## Requirements
- R1: `mode` selects the input shape. 2'b00 is serial and takes `din[0]`. 2'b01 is nibble and takes `din[3:0]`. 2'b10 is byte and takes `din[7:0]`. In byte mode every sampling edge produces `byte_vld`=1, and the sampled byte appears on `byte_out` in the cycle after that edge.
- R2: In nibble mode, two successive nibbles form one byte, with the earlier nibble in bits [7:4]. `byte_vld` is raised only after the second nibble. `din[7:4]` is ignored.
- R3: In serial mode, eight successive bits form one byte, with the earliest bit in bit 7. `byte_vld` is raised only after every eighth bit.
- R4: In nibble and byte modes, the data bits used by the mode are checked together with `din_par`. With `par_odd`=0, the total count of ones must be even. With `par_odd`=1, it must be odd. A transfer that breaks this rule sets `perr_sticky` in the cycle after its sampling edge.
- R5: In serial mode, no value of `din_par` or the data ever sets `perr_sticky`.
- R6: `perr_sticky` holds at 1 until a cycle with `clr_perr`=1. If a new error arrives in that same cycle, the error wins and the flag stays at 1.
- R7: `irq` is 1 exactly when `perr_sticky` is 1 and `perr_mask` is 0.
- R8: With `edge_rise`=1, data is taken at the rising clock edge. With `edge_rise`=0, data is taken at the falling edge that comes half a cycle earlier. Both choices give the same output latency.
- R9: The reserved encoding 2'b11 of `mode` behaves exactly as byte mode.
- R10: A change of `mode` restarts assembly. The first unit sampled under the new mode becomes the top of the next byte.
- R11: While `rst` is high, and in the cycle after it, `byte_vld`, `byte_out`, `perr_sticky` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Input shape: 00 serial, 01 nibble, 10/11 byte |
| edge_rise | input | 1 | 1 samples on the rising edge, 0 on the falling edge |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| din | input | 8 | Line data; serial uses bit 0, nibble uses bits 3:0 |
| din_par | input | 1 | Parity bit for each parallel transfer |
| clr_perr | input | 1 | Write-one-to-clear strobe for the sticky flag |
| perr_mask | input | 1 | Blocks the sticky flag from reaching `irq` |
| byte_out | output | 8 | Assembled byte |
| byte_vld | output | 1 | One-cycle strobe marking a new `byte_out` |
| perr_sticky | output | 1 | Sticky parity-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- Byte mode yields a byte on every edge.
- Serial mode never yields two valid strobes in a row.
- Serial mode never raises the error flag.
- The flag holds until it is cleared.
- The mask blocks the interrupt.

The bench scenarios check the things a property cannot see: the packed byte values and their bit order, the exact parity sense for chosen data, which of two values is caught by the falling-edge setting, set-over-clear priority, and the restart of assembly after a mode change.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        LM_SERIAL = 2'b00,
        LM_NIBBLE = 2'b01,
        LM_BYTE   = 2'b10,
        LM_RSVD   = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] bits;
        logic              par;
    } xfer_t;

    // Number of line transfers that make one byte in a given mode.
    function automatic logic [CNT_W:0] units_per_byte(line_mode_e m);
        case (m)
            LM_SERIAL: return (CNT_W+1)'(BYTE_W);
            LM_NIBBLE: return (CNT_W+1)'(BYTE_W / NIB_W);
            default:   return (CNT_W+1)'(1);
        endcase
    endfunction

endpackage

// File: rtl/lrt_edge_sampler.sv
module lrt_edge_sampler
    import lrt_pkg::*;
(
    input  logic              clk,
    input  logic              edge_rise,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_par,
    output xfer_t             smp
);
    xfer_t fall_q;

    // Falling-edge capture, consumed at the following rising edge.
    always_ff @(negedge clk) begin
        fall_q.bits <= din;
        fall_q.par  <= din_par;
    end

    always_comb begin
        if (edge_rise) begin
            smp.bits = din;
            smp.par  = din_par;
        end else begin
            smp = fall_q;
        end
    end
endmodule

// File: rtl/lrt_packer.sv
module lrt_packer
    import lrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_mode_e        mode,
    input  logic [BYTE_W-1:0] bits,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic [BYTE_W-1:0] sr_q;
    logic [BYTE_W-1:0] sr_nxt;
    line_mode_e        prev_q;
    logic              last;

    always_comb begin
        cnt_eff = (mode != prev_q) ? '0 : cnt_q;
        last    = ({1'b0, cnt_eff} == units_per_byte(mode) - 1'b1);
        case (mode)
            LM_SERIAL: sr_nxt = {sr_q[BYTE_W-2:0], bits[0]};
            LM_NIBBLE: sr_nxt = {sr_q[BYTE_W-NIB_W-1:0], bits[NIB_W-1:0]};
            default:   sr_nxt = bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            sr_q     <= '0;
            prev_q   <= mode;
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            prev_q   <= mode;
            sr_q     <= sr_nxt;
            byte_vld <= last;
            if (last) begin
                byte_out <= sr_nxt;
                cnt_q    <= '0;
            end else begin
                cnt_q    <= cnt_eff + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lrt_parity.sv
module lrt_parity
    import lrt_pkg::*;
(
    input  line_mode_e mode,
    input  logic       par_odd,
    input  xfer_t      smp,
    output logic       err
);
    logic ones;
    logic active;

    always_comb begin
        active = (mode != LM_SERIAL);
        ones   = (mode == LM_NIBBLE) ? ^smp.bits[NIB_W-1:0] : ^smp.bits;
        err    = active && ((ones ^ smp.par) != par_odd);
    end
endmodule

// File: rtl/line_retimer.sv
module line_retimer
    import lrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              edge_rise,
    input  logic              par_odd,
    input  logic [BYTE_W-1:0] din,
    input  logic              din_par,
    input  logic              clr_perr,
    input  logic              perr_mask,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              perr_sticky,
    output logic              irq
);
    line_mode_e lmode;
    xfer_t      smp;
    logic       par_err;

    assign lmode = line_mode_e'(mode);

    lrt_edge_sampler u_smp (
        .clk      (clk),
        .edge_rise(edge_rise),
        .din      (din),
        .din_par  (din_par),
        .smp      (smp)
    );

    lrt_packer u_pack (
        .clk     (clk),
        .rst     (rst),
        .mode    (lmode),
        .bits    (smp.bits),
        .byte_out(byte_out),
        .byte_vld(byte_vld)
    );

    lrt_parity u_par (
        .mode   (lmode),
        .par_odd(par_odd),
        .smp    (smp),
        .err    (par_err)
    );

    // A new error takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            perr_sticky <= 1'b0;
        else if (par_err)
            perr_sticky <= 1'b1;
        else if (clr_perr)
            perr_sticky <= 1'b0;
    end

    assign irq = perr_sticky & ~perr_mask;
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       clr_perr,
    input logic       perr_mask,
    input logic       byte_vld,
    input logic       perr_sticky,
    input logic       irq
);
    p_byte_every_edge_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode[1])) |-> byte_vld)
        else $error("byte mode skipped an output");

    p_serial_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && mode == 2'b00) |=> !byte_vld)
        else $error("serial mode produced back-to-back bytes");

    p_serial_no_err_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_sticky) |-> ($past(mode) != 2'b00))
        else $error("error flag rose from a serial transfer");

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (perr_sticky && !clr_perr) |=> perr_sticky)
        else $error("sticky flag dropped without a clear");

    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (perr_mask || !perr_sticky) |-> !irq)
        else $error("interrupt raised while masked or idle");

    p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (perr_sticky && !perr_mask) |-> irq)
        else $error("unmasked error did not raise interrupt");
endmodule

bind line_retimer lrt_checker u_lrt_checker (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .clr_perr   (clr_perr),
    .perr_mask  (perr_mask),
    .byte_vld   (byte_vld),
    .perr_sticky(perr_sticky),
    .irq        (irq)
);

// File: tb/line_retimer_bench.sv
module line_retimer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b10;
    logic       edge_rise = 1'b1;
    logic       par_odd = 1'b0;
    logic [7:0] din = '0;
    logic       din_par = 1'b0;
    logic       clr_perr = 1'b0;
    logic       perr_mask = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       perr_sticky;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_retimer u_line_retimer (
        .clk(clk), .rst(rst), .mode(mode), .edge_rise(edge_rise),
        .par_odd(par_odd), .din(din), .din_par(din_par),
        .clr_perr(clr_perr), .perr_mask(perr_mask),
        .byte_out(byte_out), .byte_vld(byte_vld),
        .perr_sticky(perr_sticky), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [7:0] d, input logic nib, input logic odd);
        logic ones;
        ones = nib ? ^d[3:0] : ^d;
        return ones ^ odd;
    endfunction

    // Drive one transfer, pass its rising edge, settle 2 time units after.
    task automatic step(input logic [7:0] d, input logic p);
        din = d;
        din_par = p;
        @(posedge clk);
        #2;
    endtask

    task automatic send_byte_good(input logic [7:0] d);
        step(d, good_par(d, 1'b0, par_odd));
    endtask

    task automatic clear_flag();
        clr_perr = 1'b1;
        send_byte_good(8'h00);
        clr_perr = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk); #2;
        check("R11 vld in reset", byte_vld, 0);
        check("R11 sticky in reset", perr_sticky, 0);
        check("R11 irq in reset", irq, 0);
        check("R11 byte in reset", byte_out, 0);
        rst = 1'b0;
    endtask

    task automatic t_byte_mode();
        logic [7:0] v[3] = '{8'h3C, 8'hA7, 8'h01};
        mode = 2'b10;
        foreach (v[i]) begin
            send_byte_good(v[i]);
            check("R1 byte vld", byte_vld, 1);
            check("R1 byte value", byte_out, v[i]);
        end
        check("R4 no error on good parity", perr_sticky, 0);
    endtask

    task automatic t_nibble_mode();
        mode = 2'b01;
        step(8'hFA, good_par(8'h0A, 1'b1, par_odd));
        check("R2 no vld after first nibble", byte_vld, 0);
        step(8'h95, good_par(8'h05, 1'b1, par_odd));
        check("R2 vld after second nibble", byte_vld, 1);
        check("R2 nibble byte high first", byte_out, 8'hA5);
        check("R2 upper din ignored by parity", perr_sticky, 0);
    endtask

    task automatic t_serial_mode();
        logic [7:0] v = 8'hC3;
        mode = 2'b00;
        for (int i = 7; i >= 0; i--) begin
            step({7'h7F, v[i]}, i[0]);
            if (i != 0) check("R3 no vld mid byte", byte_vld, 0);
        end
        check("R3 vld after eighth bit", byte_vld, 1);
        check("R3 serial byte msb first", byte_out, v);
        check("R5 serial never errors", perr_sticky, 0);
    endtask

    task automatic t_parity_even();
        mode = 2'b10;
        par_odd = 1'b0;
        step(8'h07, 1'b0);
        check("R4 even parity error sets flag", perr_sticky, 1);
        check("R7 irq unmasked", irq, 1);
        perr_mask = 1'b1;
        #1;
        check("R7 irq masked", irq, 0);
        check("R6 flag kept while masked", perr_sticky, 1);
        perr_mask = 1'b0;
        send_byte_good(8'h11);
        check("R6 flag holds with no clear", perr_sticky, 1);
        clr_perr = 1'b1;
        step(8'h01, 1'b0);
        clr_perr = 1'b0;
        check("R6 set wins over clear", perr_sticky, 1);
        clear_flag();
        check("R6 write-one clears flag", perr_sticky, 0);
        check("R7 irq drops after clear", irq, 0);
    endtask

    task automatic t_parity_odd();
        mode = 2'b10;
        par_odd = 1'b1;
        step(8'h07, 1'b0);
        check("R4 odd parity accepted", perr_sticky, 0);
        step(8'h03, 1'b0);
        check("R4 odd parity error", perr_sticky, 1);
        clear_flag();
        mode = 2'b01;
        step(8'h01, 1'b1);
        check("R4 odd nibble error", perr_sticky, 1);
        mode = 2'b10;
        clear_flag();
        par_odd = 1'b0;
    endtask

    task automatic t_edge_select();
        mode = 2'b10;
        edge_rise = 1'b0;
        send_byte_good(8'h00);
        din = 8'h5A; din_par = good_par(8'h5A, 1'b0, 1'b0);
        #5;
        din = 8'h81; din_par = good_par(8'h81, 1'b0, 1'b0);
        @(posedge clk); #2;
        check("R8 falling edge takes earlier value", byte_out, 8'h5A);
        edge_rise = 1'b1;
        din = 8'h5A; din_par = good_par(8'h5A, 1'b0, 1'b0);
        #5;
        din = 8'h81; din_par = good_par(8'h81, 1'b0, 1'b0);
        @(posedge clk); #2;
        check("R8 rising edge takes later value", byte_out, 8'h81);
        check("R8 no parity error", perr_sticky, 0);
    endtask

    task automatic t_reserved_mode();
        mode = 2'b11;
        send_byte_good(8'hE4);
        check("R9 reserved vld", byte_vld, 1);
        check("R9 reserved byte", byte_out, 8'hE4);
        step(8'hE4, ~good_par(8'hE4, 1'b0, par_odd));
        check("R9 reserved checks parity", perr_sticky, 1);
        clear_flag();
    endtask

    task automatic t_restart();
        mode = 2'b00;
        step(8'h01, 1'b0);
        step(8'h00, 1'b0);
        step(8'h01, 1'b0);
        mode = 2'b01;
        step(8'h06, good_par(8'h06, 1'b1, par_odd));
        check("R10 restart no vld on first nibble", byte_vld, 0);
        step(8'h09, good_par(8'h09, 1'b1, par_odd));
        check("R10 restart vld", byte_vld, 1);
        check("R10 restart byte", byte_out, 8'h69);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_byte_mode();
        t_nibble_mode();
        t_serial_mode();
        t_parity_even();
        t_parity_odd();
        t_edge_select();
        t_reserved_mode();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule